// File: doc/BRIEF.md
# Compare Flags and Conditional Branch Unit

This block keeps the two condition flags of a small processor, zero and negative, and decides where the program counter goes after a jump instruction. A compare operation sets the flags from a register value and an operand. Zero reports equality. Negative reports that the register value is smaller than the operand when both are read as signed two's-complement numbers. No other operation writes the flags.

A conditional jump carries its condition code in the 4-bit main-register field of the instruction, not in the opcode. The unit tests that code against the flags as they stood before the current cycle. If the condition holds, the unit loads the program counter with the target operand. If it does not hold, the program counter keeps the already-incremented fetch address. An unconditional jump always loads the target.

All outputs are registered and are valid one clock edge after the operation strobe. A parameter can remove the four derived conditions, which leaves only the equal and less tests.

Top module: `cbu_top`

## Requirements
- R1: While reset is high, and at the first edge after it, flag_z, flag_n and br_taken are 0 and pc_next is 0.
- R2: One edge after op_cmp, flag_z is 1 if reg_val equals operand and 0 otherwise.
- R3: One edge after op_cmp, flag_n is 1 if reg_val is less than operand as signed 32-bit integers and 0 otherwise. flag_z and flag_n are never both 1.
- R4: The flags keep their value in any cycle without op_cmp, including cycles with jumps.
- R5: One edge after op_jmp, br_taken is 1 and pc_next equals target. op_jmp takes precedence over op_jcond.
- R6: With op_jcond, cond_sel 0 (equal) is taken when Z=1, and cond_sel 2 (less) is taken only when N=1 and Z=0.
- R7: With op_jcond, cond_sel 1 (not equal) is taken when Z=0, 3 (less-or-equal) when N=1 or Z=1, 4 (greater) when N=0 and Z=0, and 5 (greater-or-equal) when N=0.
- R8: cond_sel values 6 to 15 are never taken.
- R9: When no jump is taken, br_taken is 0 and pc_next equals pc_inc one edge later.
- R10: A conditional jump in the same cycle as a compare is evaluated against the flags held before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_cmp | input | 1 | Compare strobe |
| op_jmp | input | 1 | Unconditional jump strobe |
| op_jcond | input | 1 | Conditional jump strobe |
| cond_sel | input | 4 | Condition code from the main-register field |
| reg_val | input | 32 | Register value to compare |
| operand | input | 32 | Compare operand |
| target | input | 32 | Jump target operand |
| pc_inc | input | 32 | Already-incremented program counter |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| br_taken | output | 1 | Jump taken in the previous cycle |
| pc_next | output | 32 | Program counter to use next |

## Verification
Every result of this block, the flags as well as br_taken and pc_next, is due exactly one rising edge after the cycle in which the strobe is presented. The bench drives each operation on a falling edge and waits through one rising edge. It checks on the next falling edge and clears the strobes at that same point, so the outputs it reads come from that single operation only. For the same-cycle compare-and-branch case, the branch result and the new flags are both read after that one edge. The branch result must reflect the old flags and the flags must show the new compare.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int CC_W = 4;
  typedef enum logic [CC_W-1:0] {
    CC_EQ = 4'd0,
    CC_NE = 4'd1,
    CC_LT = 4'd2,
    CC_LE = 4'd3,
    CC_GT = 4'd4,
    CC_GE = 4'd5
  } cc_e;
endpackage

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         z,
  output logic         n
);
  logic eq_c, lt_c;

  assign eq_c = (a == b);
  assign lt_c = ($signed(a) < $signed(b));

  always_ff @(posedge clk) begin
    if (rst) begin
      z <= 1'b0;
      n <= 1'b0;
    end else if (upd) begin
      z <= eq_c;
      n <= lt_c;
    end
  end

  // R3: equal and less cannot both hold
  a_r3_z_n_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(z && n));

  // R4: flags move only on a compare
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(z) && $stable(n)));
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
#(
  parameter bit EXT_CONDS = 1'b1
) (
  input  logic [CC_W-1:0] sel,
  input  logic            z,
  input  logic            n,
  output logic            hit
);
  generate
    if (EXT_CONDS) begin : g_full
      always_comb begin
        case (sel)
          CC_EQ:   hit = z;
          CC_NE:   hit = !z;
          CC_LT:   hit = n && !z;
          CC_LE:   hit = n || z;
          CC_GT:   hit = !n && !z;
          CC_GE:   hit = !n;
          default: hit = 1'b0;
        endcase
      end
    end else begin : g_basic
      always_comb begin
        case (sel)
          CC_EQ:   hit = z;
          CC_LT:   hit = n && !z;
          default: hit = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/cbu_pc_sel.sv
module cbu_pc_sel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         jmp,
  input  logic         jcond,
  input  logic         hit,
  input  logic [W-1:0] target,
  input  logic [W-1:0] pc_inc,
  output logic         taken,
  output logic [W-1:0] pc_next
);
  logic take_c;

  assign take_c = jmp || (jcond && hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      taken   <= 1'b0;
      pc_next <= '0;
    end else begin
      taken   <= take_c;
      pc_next <= take_c ? target : pc_inc;
    end
  end

  // R5: an unconditional jump always lands on the target
  a_r5_jump_loads_target: assert property (@(posedge clk) disable iff (rst)
    jmp |=> (taken && pc_next == $past(target)));

  // R9: with no jump strobe the counter follows the incremented value
  a_r9_idle_keeps_pc: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !jcond) |=> (!taken && pc_next == $past(pc_inc)));
endmodule

// File: rtl/cbu_top.sv
module cbu_top
  import cbu_pkg::*;
#(
  parameter int W         = 32,
  parameter bit EXT_CONDS = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_cmp,
  input  logic            op_jmp,
  input  logic            op_jcond,
  input  logic [CC_W-1:0] cond_sel,
  input  logic [W-1:0]    reg_val,
  input  logic [W-1:0]    operand,
  input  logic [W-1:0]    target,
  input  logic [W-1:0]    pc_inc,
  output logic            flag_z,
  output logic            flag_n,
  output logic            br_taken,
  output logic [W-1:0]    pc_next
);
  logic cond_hit;

  cbu_flag_reg #(.W(W)) u_flags (
    .clk (clk),
    .rst (rst),
    .upd (op_cmp),
    .a   (reg_val),
    .b   (operand),
    .z   (flag_z),
    .n   (flag_n)
  );

  cbu_cond_eval #(.EXT_CONDS(EXT_CONDS)) u_cond (
    .sel (cond_sel),
    .z   (flag_z),
    .n   (flag_n),
    .hit (cond_hit)
  );

  cbu_pc_sel #(.W(W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .jmp     (op_jmp),
    .jcond   (op_jcond),
    .hit     (cond_hit),
    .target  (target),
    .pc_inc  (pc_inc),
    .taken   (br_taken),
    .pc_next (pc_next)
  );

  // R8: codes above the defined set never branch
  a_r8_unused_code_not_taken: assert property (@(posedge clk) disable iff (rst)
    (op_jcond && !op_jmp && cond_sel > 4'd5) |=> !br_taken);

  // R6: an equal-condition branch follows the zero flag held that cycle
  a_r6_eq_follows_z: assert property (@(posedge clk) disable iff (rst)
    (op_jcond && !op_jmp && cond_sel == 4'd0) |=> (br_taken == $past(flag_z)));
endmodule

// File: tb/cbu_top_test.sv
module cbu_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_cmp, op_jmp, op_jcond;
  logic [3:0]  cond_sel;
  logic [31:0] reg_val, operand, target, pc_inc;
  logic        flag_z, flag_n, br_taken;
  logic [31:0] pc_next;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cbu_top uut (
    .clk(clk), .rst(rst), .op_cmp(op_cmp), .op_jmp(op_jmp), .op_jcond(op_jcond),
    .cond_sel(cond_sel), .reg_val(reg_val), .operand(operand), .target(target),
    .pc_inc(pc_inc), .flag_z(flag_z), .flag_n(flag_n), .br_taken(br_taken),
    .pc_next(pc_next)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic j, input logic jc, input logic [3:0] cc,
                      input logic [31:0] rv, input logic [31:0] opd,
                      input logic [31:0] tgt, input logic [31:0] pci);
    @(negedge clk);
    op_cmp = c; op_jmp = j; op_jcond = jc; cond_sel = cc;
    reg_val = rv; operand = opd; target = tgt; pc_inc = pci;
    @(posedge clk);
    @(negedge clk);
    op_cmp = 1'b0; op_jmp = 1'b0; op_jcond = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    op_cmp = 0; op_jmp = 0; op_jcond = 0; cond_sel = 0;
    reg_val = 0; operand = 0; target = 32'h1234; pc_inc = 32'h55;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 z", {31'b0, flag_z}, 32'd0);
    check("R1 n", {31'b0, flag_n}, 32'd0);
    check("R1 taken", {31'b0, br_taken}, 32'd0);
    check("R1 pc", pc_next, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_compare(input logic [31:0] a, input logic [31:0] b,
                           input logic ez, input logic en);
    step(1, 0, 0, 0, a, b, 32'h0, 32'h10);
    check("R2 z", {31'b0, flag_z}, {31'b0, ez});
    check("R3 n", {31'b0, flag_n}, {31'b0, en});
  endtask

  task automatic t_hold();
    t_compare(32'd9, 32'd9, 1, 0);
    step(0, 1, 0, 0, 32'd1, 32'd2, 32'h200, 32'h11);
    check("R4 z after jump", {31'b0, flag_z}, 32'd1);
    check("R5 jump taken", {31'b0, br_taken}, 32'd1);
    check("R5 jump pc", pc_next, 32'h200);
    step(0, 0, 1, 4'd1, 32'd1, 32'd2, 32'h300, 32'h12);
    check("R4 z after jcond", {31'b0, flag_z}, 32'd1);
    check("R4 n after jcond", {31'b0, flag_n}, 32'd0);
    step(0, 0, 0, 0, 32'd7, 32'd8, 32'h400, 32'h13);
    check("R4 z idle", {31'b0, flag_z}, 32'd1);
    check("R9 idle taken", {31'b0, br_taken}, 32'd0);
    check("R9 idle pc", pc_next, 32'h13);
  endtask

  task automatic t_jump_priority();
    t_compare(32'd1, 32'd1, 1, 0);
    step(0, 1, 1, 4'd1, 32'd0, 32'd0, 32'h777, 32'h20);
    check("R5 jump over false jcond", {31'b0, br_taken}, 32'd1);
    check("R5 jump over false jcond pc", pc_next, 32'h777);
  endtask

  // mask bit k = expected outcome of condition code k in this flag state
  task automatic t_conds(input logic [31:0] a, input logic [31:0] b, input logic [5:0] mask);
    t_compare(a, b, a == b, $signed(a) < $signed(b));
    for (int cc = 0; cc < 16; cc++) begin
      logic exp_t;
      string tag;
      exp_t = (cc < 6) ? mask[cc] : 1'b0;
      if (cc == 0 || cc == 2) tag = "R6 cond";
      else if (cc < 6)        tag = "R7 cond";
      else                    tag = "R8 cond";
      step(0, 0, 1, cc[3:0], 32'd0, 32'd0, 32'hA000 + cc, 32'hB000 + cc);
      check($sformatf("%s %0d taken", tag, cc), {31'b0, br_taken}, {31'b0, exp_t});
      check($sformatf("%s %0d pc (R9 when not taken)", tag, cc), pc_next,
            exp_t ? 32'hA000 + cc : 32'hB000 + cc);
    end
  endtask

  task automatic t_same_cycle();
    t_compare(32'd8, 32'd3, 0, 0);
    step(1, 0, 1, 4'd0, 32'd5, 32'd5, 32'h900, 32'h30);
    check("R10 old flags used", {31'b0, br_taken}, 32'd0);
    check("R10 pc", pc_next, 32'h30);
    check("R10 new z", {31'b0, flag_z}, 32'd1);
    step(0, 0, 1, 4'd0, 32'd0, 32'd0, 32'h901, 32'h31);
    check("R10 next cycle sees new z", {31'b0, br_taken}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_compare(32'd5, 32'd5, 1, 0);
    t_compare(32'd3, 32'd7, 0, 1);
    t_compare(32'd7, 32'd3, 0, 0);
    t_compare(32'hFFFF_FFFF, 32'd1, 0, 1);
    t_compare(32'd1, 32'hFFFF_FFFF, 0, 0);
    t_compare(32'h8000_0000, 32'h7FFF_FFFF, 0, 1);
    t_hold();
    t_jump_priority();
    t_conds(32'd4, 32'd4, 6'b101001);
    t_conds(32'hFFFF_FFF0, 32'd2, 6'b001110);
    t_conds(32'd20, 32'd2, 6'b110010);
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule